// File: doc/BRIEF.md
# Serial controller register bank with FIFO status

This block is the software-visible face of a serial controller that has a receive FIFO. It stores the mode, bit-rate, control, FIFO-control and port settings, and it keeps five status flags: transmit-end, transmit-empty, break, receive-full and data-ready. A simple synchronous bus reaches these registers at byte offsets. Write strobes act on the rising clock edge, and read data is combinational from the current state.

Towards the datapath, the block issues a one-cycle transmit strobe that carries the byte written. It issues a receive-FIFO pop strobe during a read of the receive-data register, a one-cycle FIFO reset pulse and a two-bit trigger selection. The receive path reports four things: trigger reached, timeout, the FIFO count and break. From these, the block raises the receive interrupt. The transmit interrupt mirrors a control bit. The serial shifter, the FIFO storage and the baud generator lie outside this block.

Top module: `sfc_csr`

## Requirements
- R1: After reset the registers hold these values: mode 0x00, bit rate 0xFF, control 0x20, FIFO control 0x00 and port 0x00. Transmit-end and transmit-empty are set, the other flags are clear, and both interrupts are low.
- R2: Writes at offset 0x00 (mode) keep only the bits of mask 0x7B. Writes at 0x08 (control) keep mask 0xFA, and writes at 0x20 (port) keep mask 0xF3. Offsets 0x04 (bit rate) and 0x18 (FIFO control) store all 8 bits. Each of these registers reads back at its own offset.
- R3: A read at offset 0x10 returns the status flags at fixed bit positions: transmit-end at bit 6, transmit-empty at bit 5, break at bit 4, receive-full at bit 1 and data-ready at bit 0. Bits 7, 3 and 2 read as 0.
- R4: A write at 0x10 clears each flag whose bit is written as 0 and leaves unchanged each flag whose bit is written as 1. When a bus clear and a hardware set hit the same flag in the same cycle, the flag ends up clear.
- R5: A control write with bit 5 at 0 sets transmit-end. From the cycle after any control write, tx_irq equals control bit 7. A control write with bit 6 at 0 drops rx_irq.
- R6: A write at 0x0C raises tx_valid for exactly the next cycle, with tx_data equal to the byte written. The same write clears transmit-empty.
- R7: A status read returns the flags as they were before the read. After the read, if control bit 5 is 1, transmit-empty and transmit-end are both set.
- R8: A pulse on rx_trig or rx_timeout sets receive-full, and a pulse on rx_timeout also sets data-ready. rx_irq is raised on either pulse when control bit 6 is 1. A status write with bit 1 or bit 0 at 0 drops rx_irq. A clear in the same cycle wins over a set.
- R9: A read at 0x14 with rx_count nonzero returns rx_data and raises rx_pop in that same cycle. The read clears receive-full when rx_count−1 is below the trigger level. The trigger level is 1, 4, 8 or 14 for a trigger selection of 0, 1, 2 or 3. With rx_count at 0, the read returns 0 and rx_pop stays low.
- R10: trig_sel equals FIFO-control bits 7:6. A FIFO-control write with bit 1 at 1 raises fifo_rst for exactly the next cycle and clears receive-full.
- R11: A pulse on rx_brk sets the break flag.
- R12: A read at 0x1C returns rx_count. Reads at 0x0C, at 0x24 and at any unmapped offset return 0. Writes at 0x24 or at an unmapped offset change no register, flag or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; ignored while bus_wr is high |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_count | input | 5 | Number of bytes held in the receive FIFO |
| rx_trig | input | 1 | Pulse: FIFO count reached the trigger level |
| rx_timeout | input | 1 | Pulse: receive timeout expired |
| rx_brk | input | 1 | Pulse: break condition received |
| fifo_rst | output | 1 | One-cycle FIFO reset pulse |
| trig_sel | output | 2 | Receive trigger selection |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A fixed-seed random mix drives the bench. It combines writes of arbitrary bytes, which tell the masked registers apart from the full-width ones, with status reads, which reveal the flag rearm rule. It also varies FIFO counts across the trigger levels, which tells the pop-clear rule apart from a plain clear on every pop. Receive events are scattered randomly so that some land in the same cycle as a clearing write. Directed sequences aim at the cases that random traffic seldom hits: a status write that clears receive-full while a trigger pulse arrives, the fresh-versus-stale value of a status read after a transmit write, and a break pulse. A FIFO reset and a read of an empty FIFO are also driven directly.

// File: rtl/sfc_csr_pkg.sv
package sfc_csr_pkg;

    localparam int DATA_W = 8;

    localparam int OFS_MODE = 'h00;
    localparam int OFS_RATE = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_TXD  = 'h0C;
    localparam int OFS_STS  = 'h10;
    localparam int OFS_RXD  = 'h14;
    localparam int OFS_FCTL = 'h18;
    localparam int OFS_CNT  = 'h1C;
    localparam int OFS_PORT = 'h20;
    localparam int OFS_LSR  = 'h24;

    localparam logic [DATA_W-1:0] MODE_MASK = 8'h7B;
    localparam logic [DATA_W-1:0] CTRL_MASK = 8'hFA;
    localparam logic [DATA_W-1:0] PORT_MASK = 8'hF3;

    localparam logic [DATA_W-1:0] MODE_RST = 8'h00;
    localparam logic [DATA_W-1:0] RATE_RST = 8'hFF;
    localparam logic [DATA_W-1:0] CTRL_RST = 8'h20;
    localparam logic [DATA_W-1:0] FCTL_RST = 8'h00;
    localparam logic [DATA_W-1:0] PORT_RST = 8'h00;

    // control bit positions
    localparam int CB_TXEN  = 5;
    localparam int CB_RXIE  = 6;
    localparam int CB_TXIE  = 7;
    // FIFO control: reset request bit
    localparam int FB_RST   = 1;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rdf;
        logic dr;
    } flags_t;

    typedef struct packed {
        logic mode;
        logic rate;
        logic ctrl;
        logic txd;
        logic sts;
        logic rxd;
        logic fctl;
        logic cnt;
        logic port;
        logic lsr;
    } sel_t;

    function automatic logic [3:0] trig_level(input logic [1:0] s);
        case (s)
            2'd0:    trig_level = 4'd1;
            2'd1:    trig_level = 4'd4;
            2'd2:    trig_level = 4'd8;
            default: trig_level = 4'd14;
        endcase
    endfunction

endpackage

// File: rtl/sfc_csr_decode.sv
module sfc_csr_decode
    import sfc_csr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_t              sel
);
    always_comb begin
        sel      = '0;
        sel.mode = (addr == ADDR_W'(OFS_MODE));
        sel.rate = (addr == ADDR_W'(OFS_RATE));
        sel.ctrl = (addr == ADDR_W'(OFS_CTRL));
        sel.txd  = (addr == ADDR_W'(OFS_TXD));
        sel.sts  = (addr == ADDR_W'(OFS_STS));
        sel.rxd  = (addr == ADDR_W'(OFS_RXD));
        sel.fctl = (addr == ADDR_W'(OFS_FCTL));
        sel.cnt  = (addr == ADDR_W'(OFS_CNT));
        sel.port = (addr == ADDR_W'(OFS_PORT));
        sel.lsr  = (addr == ADDR_W'(OFS_LSR));
    end
endmodule

// File: rtl/sfc_csr_cfg.sv
module sfc_csr_cfg
    import sfc_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel_mode,
    input  logic              sel_rate,
    input  logic              sel_ctrl,
    input  logic              sel_fctl,
    input  logic              sel_port,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] rate_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] fctl_q,
    output logic [DATA_W-1:0] port_q,
    output logic              fifo_rst
);
    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] rate;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] fctl;
        logic [DATA_W-1:0] port;
        logic              frst;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.frst = 1'b0;
        if (wr) begin
            if (sel_mode) st_d.mode = wdata & MODE_MASK;
            if (sel_rate) st_d.rate = wdata;
            if (sel_ctrl) st_d.ctrl = wdata & CTRL_MASK;
            if (sel_port) st_d.port = wdata & PORT_MASK;
            if (sel_fctl) begin
                st_d.fctl = wdata;
                st_d.frst = wdata[FB_RST];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_RST;
            st_q.rate <= RATE_RST;
            st_q.ctrl <= CTRL_RST;
            st_q.fctl <= FCTL_RST;
            st_q.port <= PORT_RST;
            st_q.frst <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_q   = st_q.mode;
    assign rate_q   = st_q.rate;
    assign ctrl_q   = st_q.ctrl;
    assign fctl_q   = st_q.fctl;
    assign port_q   = st_q.port;
    assign fifo_rst = st_q.frst;

    // R10: the reset pulse follows a FIFO-control write that requested it
    a_r10_fifo_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr && sel_fctl && wdata[FB_RST] |=> fifo_rst);
    a_r10_fifo_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel_fctl) |=> !fifo_rst);
endmodule

// File: rtl/sfc_csr_flags.sv
module sfc_csr_flags
    import sfc_csr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr,
    input  logic   rd,
    input  logic   sel_ctrl,
    input  logic   sel_txd,
    input  logic   sel_sts,
    input  logic   sel_fctl,
    input  logic   wd_dr,
    input  logic   wd_rdf,
    input  logic   wd_brk,
    input  logic   wd_tde,
    input  logic   wd_tend,
    input  logic   ctrl_txen,
    input  logic   ctrl_rxie,
    input  logic   rx_trig,
    input  logic   rx_timeout,
    input  logic   rx_brk,
    input  logic   pop_clr,
    output flags_t flags,
    output logic   rx_irq
);
    typedef struct packed {
        flags_t f;
        logic   rxi;
    } fl_t;

    fl_t st_d, st_q;

    logic sts_wr, sts_rd, ctrl_wr;
    flags_t set_v, clr_v;
    logic rxi_set, rxi_clr;

    always_comb begin
        sts_wr  = wr && sel_sts;
        sts_rd  = rd && sel_sts;
        ctrl_wr = wr && sel_ctrl;

        set_v.tend = (ctrl_wr && !wd_tde) || (sts_rd && ctrl_txen);
        set_v.tde  = sts_rd && ctrl_txen;
        set_v.brk  = rx_brk;
        set_v.rdf  = rx_trig || rx_timeout;
        set_v.dr   = rx_timeout;

        clr_v.tend = sts_wr && !wd_tend;
        clr_v.tde  = (sts_wr && !wd_tde) || (wr && sel_txd);
        clr_v.brk  = sts_wr && !wd_brk;
        clr_v.rdf  = (sts_wr && !wd_rdf) || (wr && sel_fctl && wd_rdf) || pop_clr;
        clr_v.dr   = sts_wr && !wd_dr;

        rxi_set = (rx_trig || rx_timeout) && ctrl_rxie;
        rxi_clr = (ctrl_wr && !wd_tend) || (sts_wr && (!wd_rdf || !wd_dr));

        st_d   = st_q;
        st_d.f = (st_q.f | set_v) & ~clr_v;
        if (rxi_clr)      st_d.rxi = 1'b0;
        else if (rxi_set) st_d.rxi = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.f      <= '0;
            st_q.f.tend <= 1'b1;
            st_q.f.tde  <= 1'b1;
            st_q.rxi    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags  = st_q.f;
    assign rx_irq = st_q.rxi;

    // R4: a zero written to receive-full wins over a same-cycle trigger
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr && sel_sts && !wd_rdf |=> !flags.rdf);
    // R6: transmit write empties the holding flag
    a_r6_tde_clear: assert property (@(posedge clk) disable iff (!rst_n)
        wr && sel_txd |=> !flags.tde);
    // R7: status read with transmitter enabled rearms both transmit flags
    a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        rd && sel_sts && ctrl_txen |=> flags.tde && flags.tend);
    // R11: break pulse sets the break flag unless cleared in the same cycle
    a_r11_break_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_brk && !(wr && sel_sts && !wd_brk) |=> flags.brk);
    // R5: control write with receive interrupt disabled drops the line
    a_r5_rxi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr && sel_ctrl && !wd_tend |=> !rx_irq);
    // R8: receive interrupt only rises on a receive event
    a_r8_rxi_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(rx_trig || rx_timeout));
endmodule

// File: rtl/sfc_csr.sv
module sfc_csr
    import sfc_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              rx_pop,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              rx_trig,
    input  logic              rx_timeout,
    input  logic              rx_brk,
    output logic              fifo_rst,
    output logic [1:0]        trig_sel,
    output logic              tx_irq,
    output logic              rx_irq
);
    localparam int CMP_W = (CNT_W > 4 ? CNT_W : 4) + 1;

    sel_t              sel;
    logic              rd_eff;
    logic [DATA_W-1:0] mode_q, rate_q, ctrl_q, fctl_q, port_q;
    flags_t            flags;
    logic              pop_clr;
    logic [CMP_W-1:0]  cnt_less1, lvl_ext;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } tx_t;

    tx_t tx_d, tx_q;

    sfc_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    sfc_csr_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .sel_mode (sel.mode),
        .sel_rate (sel.rate),
        .sel_ctrl (sel.ctrl),
        .sel_fctl (sel.fctl),
        .sel_port (sel.port),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .rate_q   (rate_q),
        .ctrl_q   (ctrl_q),
        .fctl_q   (fctl_q),
        .port_q   (port_q),
        .fifo_rst (fifo_rst)
    );

    sfc_csr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .rd         (rd_eff),
        .sel_ctrl   (sel.ctrl),
        .sel_txd    (sel.txd),
        .sel_sts    (sel.sts),
        .sel_fctl   (sel.fctl),
        .wd_dr      (bus_wdata[0]),
        .wd_rdf     (bus_wdata[1]),
        .wd_brk     (bus_wdata[4]),
        .wd_tde     (bus_wdata[5]),
        .wd_tend    (bus_wdata[6]),
        .ctrl_txen  (ctrl_q[CB_TXEN]),
        .ctrl_rxie  (ctrl_q[CB_RXIE]),
        .rx_trig    (rx_trig),
        .rx_timeout (rx_timeout),
        .rx_brk     (rx_brk),
        .pop_clr    (pop_clr),
        .flags      (flags),
        .rx_irq     (rx_irq)
    );

    always_comb begin
        rd_eff    = bus_rd && !bus_wr;
        rx_pop    = rd_eff && sel.rxd && (rx_count != '0);
        cnt_less1 = CMP_W'(rx_count) - CMP_W'(1);
        lvl_ext   = CMP_W'(trig_level(fctl_q[7:6]));
        pop_clr   = rx_pop && (cnt_less1 < lvl_ext);
    end

    always_comb begin
        bus_rdata = '0;
        if (sel.mode) bus_rdata = mode_q;
        if (sel.rate) bus_rdata = rate_q;
        if (sel.ctrl) bus_rdata = ctrl_q;
        if (sel.sts)  bus_rdata = {1'b0, flags.tend, flags.tde, flags.brk,
                                   2'b00, flags.rdf, flags.dr};
        if (sel.rxd)  bus_rdata = (rx_count != '0) ? rx_data : '0;
        if (sel.fctl) bus_rdata = fctl_q;
        if (sel.cnt)  bus_rdata = DATA_W'(rx_count);
        if (sel.port) bus_rdata = port_q;
        if (sel.lsr)  bus_rdata = '0;
        if (sel.txd)  bus_rdata = '0;
    end

    always_comb begin
        tx_d     = tx_q;
        tx_d.vld = bus_wr && sel.txd;
        if (bus_wr && sel.txd) tx_d.dat = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign tx_valid = tx_q.vld;
    assign tx_data  = tx_q.dat;
    assign trig_sel = fctl_q[7:6];
    assign tx_irq   = ctrl_q[CB_TXIE];

    // R6: transmit strobe carries the written byte one cycle later
    a_r6_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel.txd |=> tx_valid && tx_data == $past(bus_wdata));
    // R9: no pop of an empty FIFO
    a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> rx_count != '0);
    // R5: transmit interrupt tracks the written control bit 7
    a_r5_tx_irq: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && sel.ctrl |=> tx_irq == $past(bus_wdata[7]));
endmodule

// File: tb/tb_sfc_csr.sv
`timescale 1ns/1ps
module tb_sfc_csr;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_wr, bus_rd;
    logic [5:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       rx_pop;
    logic [7:0] rx_data;
    logic [4:0] rx_count;
    logic       rx_trig, rx_timeout, rx_brk;
    logic       fifo_rst;
    logic [1:0] trig_sel;
    logic       tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag_ovr = "";

    always #2.5 clk = ~clk;

    sfc_csr dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_count(rx_count), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .rx_brk(rx_brk), .fifo_rst(fifo_rst),
        .trig_sel(trig_sel), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    // bench model state
    logic [7:0] m_mode, m_rate, m_ctrl, m_fctl, m_port;
    logic m_tend, m_tde, m_brk, m_rdf, m_dr, m_rxi, m_txv, m_frst;
    logic [7:0] m_txd;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'd0: lvl = 1;
            2'd1: lvl = 4;
            2'd2: lvl = 8;
            default: lvl = 14;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [5:0] a, input logic [4:0] c,
                                             input logic [7:0] rd);
        case (a)
            6'h00: exp_read = m_mode;
            6'h04: exp_read = m_rate;
            6'h08: exp_read = m_ctrl;
            6'h10: exp_read = {1'b0, m_tend, m_tde, m_brk, 2'b00, m_rdf, m_dr};
            6'h14: exp_read = (c != 0) ? rd : 8'h00;
            6'h18: exp_read = m_fctl;
            6'h1C: exp_read = {3'b000, c};
            6'h20: exp_read = m_port;
            default: exp_read = 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] a);
        case (a)
            6'h00, 6'h04, 6'h08, 6'h18, 6'h20: tag_of = "R2";
            6'h10: tag_of = "R3";
            6'h14: tag_of = "R9";
            default: tag_of = "R12";
        endcase
    endfunction

    task automatic model_reset();
        m_mode = 8'h00; m_rate = 8'hFF; m_ctrl = 8'h20; m_fctl = 8'h00; m_port = 8'h00;
        m_tend = 1; m_tde = 1; m_brk = 0; m_rdf = 0; m_dr = 0; m_rxi = 0;
        m_txv = 0; m_frst = 0; m_txd = 8'h00;
    endtask

    task automatic cyc(input logic w, input logic r, input logic [5:0] a, input logic [7:0] d,
                       input logic trg, input logic tmo, input logic bk,
                       input logic [4:0] c, input logic [7:0] rxd);
        logic rde, pop, pclr;
        logic s_tend, s_tde, c_tend, c_tde, c_brk, c_rdf, c_dr, xs, xc;
        string t;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        rx_trig = trg; rx_timeout = tmo; rx_brk = bk; rx_count = c; rx_data = rxd;
        #1;
        rde = r && !w;
        pop = rde && a == 6'h14 && c != 0;
        if (rde) begin
            t = (tag_ovr != "") ? tag_ovr : tag_of(a);
            chk(t, bus_rdata, exp_read(a, c, rxd));
        end
        chk("R9", {7'b0, rx_pop}, {7'b0, pop});
        pclr   = pop && (int'(c) - 1 < lvl(m_fctl[7:6]));
        s_tend = (w && a == 6'h08 && !d[5]) || (rde && a == 6'h10 && m_ctrl[5]);
        s_tde  = rde && a == 6'h10 && m_ctrl[5];
        c_tend = w && a == 6'h10 && !d[6];
        c_tde  = (w && a == 6'h10 && !d[5]) || (w && a == 6'h0C);
        c_brk  = w && a == 6'h10 && !d[4];
        c_rdf  = (w && a == 6'h10 && !d[1]) || (w && a == 6'h18 && d[1]) || pclr;
        c_dr   = w && a == 6'h10 && !d[0];
        xc     = (w && a == 6'h08 && !d[6]) || (w && a == 6'h10 && (!d[1] || !d[0]));
        xs     = (trg || tmo) && m_ctrl[6];
        @(posedge clk);
        #1;
        m_tend = c_tend ? 1'b0 : (s_tend ? 1'b1 : m_tend);
        m_tde  = c_tde  ? 1'b0 : (s_tde  ? 1'b1 : m_tde);
        m_brk  = c_brk  ? 1'b0 : (bk     ? 1'b1 : m_brk);
        m_rdf  = c_rdf  ? 1'b0 : ((trg || tmo) ? 1'b1 : m_rdf);
        m_dr   = c_dr   ? 1'b0 : (tmo    ? 1'b1 : m_dr);
        m_rxi  = xc ? 1'b0 : (xs ? 1'b1 : m_rxi);
        if (w) begin
            case (a)
                6'h00: m_mode = d & 8'h7B;
                6'h04: m_rate = d;
                6'h08: m_ctrl = d & 8'hFA;
                6'h18: m_fctl = d;
                6'h20: m_port = d & 8'hF3;
                default: ;
            endcase
        end
        m_txv  = w && a == 6'h0C;
        if (m_txv) m_txd = d;
        m_frst = w && a == 6'h18 && d[1];
        chk("R6",  {7'b0, tx_valid}, {7'b0, m_txv});
        if (m_txv) chk("R6", tx_data, m_txd);
        chk("R10", {7'b0, fifo_rst}, {7'b0, m_frst});
        chk("R10", {6'b0, trig_sel}, {6'b0, m_fctl[7:6]});
        chk("R5",  {7'b0, tx_irq},   {7'b0, m_ctrl[7]});
        chk("R8",  {7'b0, rx_irq},   {7'b0, m_rxi});
    endtask

    task automatic rd_reg(input logic [5:0] a, input string t);
        tag_ovr = t;
        cyc(0, 1, a, 8'h00, 0, 0, 0, 5'd3, 8'hA5);
        tag_ovr = "";
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        cyc(1, 0, a, d, 0, 0, 0, 5'd3, 8'hA5);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] addrs [13];
        void'($urandom(32'h5EED_1234));
        addrs = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18, 6'h1C,
                  6'h20, 6'h24, 6'h28, 6'h3C, 6'h02};
        bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rx_trig = 0; rx_timeout = 0; rx_brk = 0; rx_count = 0; rx_data = 0;
        rst_n = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        rd_reg(6'h00, "R1"); rd_reg(6'h04, "R1"); rd_reg(6'h08, "R1");
        rd_reg(6'h18, "R1"); rd_reg(6'h20, "R1"); rd_reg(6'h10, "R1");
        chk("R1", {6'b0, tx_irq, rx_irq}, 8'h00);

        // R2 masks
        wr_reg(6'h00, 8'hFF); rd_reg(6'h00, "R2");
        wr_reg(6'h20, 8'hFF); rd_reg(6'h20, "R2");
        wr_reg(6'h04, 8'h5A); rd_reg(6'h04, "R2");

        // R7: transmit write clears empty; read shows stale then rearms
        wr_reg(6'h0C, 8'h3C); rd_reg(6'h10, "R7"); rd_reg(6'h10, "R7");

        // R8: enable rx interrupt, timeout sets full and ready
        wr_reg(6'h08, 8'h60);
        cyc(0, 0, 6'h00, 8'h00, 0, 1, 0, 5'd2, 8'h00);
        rd_reg(6'h10, "R8");
        // R4: clear full while a trigger arrives: clear wins
        cyc(1, 0, 6'h10, 8'hFD, 1, 0, 0, 5'd2, 8'h00);
        rd_reg(6'h10, "R4");
        // R11 break
        cyc(0, 0, 6'h00, 8'h00, 0, 0, 1, 5'd0, 8'h00);
        rd_reg(6'h10, "R11");
        // R10 FIFO reset with trigger 8, clears full
        cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, 5'd8, 8'h00);
        wr_reg(6'h18, 8'h82); rd_reg(6'h10, "R10");
        // R9: pop above level keeps full, at level clears; empty read
        cyc(0, 0, 6'h00, 8'h00, 1, 0, 0, 5'd10, 8'h00);
        cyc(0, 1, 6'h14, 8'h00, 0, 0, 0, 5'd10, 8'h77);
        rd_reg(6'h10, "R9");
        cyc(0, 1, 6'h14, 8'h00, 0, 0, 0, 5'd8, 8'h78);
        rd_reg(6'h10, "R9");
        cyc(0, 1, 6'h14, 8'h00, 0, 0, 0, 5'd0, 8'h79);
        // R12 ignored writes
        wr_reg(6'h24, 8'hFF); wr_reg(6'h3C, 8'hFF);
        rd_reg(6'h24, "R12"); rd_reg(6'h3C, "R12"); rd_reg(6'h1C, "R12");
        rd_reg(6'h10, "R12"); rd_reg(6'h08, "R12");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] op;
            logic [5:0] a;
            op = 4'($urandom_range(0, 9));
            a  = addrs[$urandom_range(0, 12)];
            cyc(op < 4, op >= 4 && op < 8, a, 8'($urandom),
                ($urandom_range(0, 9) == 0), ($urandom_range(0, 14) == 0),
                ($urandom_range(0, 19) == 0), 5'($urandom_range(0, 16)), 8'($urandom));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule